// File: doc/BRIEF.md
# Split-Phase Shared Memory Access Sequencer

This block shares one memory bus between a video fetcher and a CPU by dividing each E clock period into fixed slots. It runs from a fast reference clock that ticks eight times per E period and produces E itself. While E is low, the bus serves a video fetch. The fetch reads one 16-bit word from main RAM. The low byte goes to the video port at once. The high byte is held and sent when E rises.

While E is high, the bus serves the CPU in two steps. First, a lookup RAM is addressed with the CPU's page index. Its 16-bit page value is latched. Then main RAM is addressed with that page value joined to the CPU offset. The block reads or writes one byte lane directly for the CPU. Main RAM is made of two 8-bit banks, a high bank and a low bank, which together form one 16-bit word.

Both output streams carry a valid strobe and have no ready input. The slot schedule is fixed, so a sink cannot stall either stream. It must accept every beat in the cycle that the beat is valid. The CPU-side inputs must stay stable for the whole E-high interval. The video address must stay stable for the whole E-low interval.

Top module: `ssq_mem_sequencer`

## Requirements
- R1: E is low for reference cycles 0..3 and high for cycles 4..7 of each eight-cycle period. After reset is released, the period begins at cycle 0.
- R2: During cycles 0..3 the shared address carries the video word address, zero-extended. Main RAM is enabled for the video fetch only in cycle 1.
- R3: The 16-bit word read in cycle 1 is presented on the video port in two beats. The low byte appears with a valid pulse in cycle 2. The high byte appears with a valid pulse in cycle 4, the first cycle of E high. No other cycle carries a video valid pulse.
- R4: During cycles 4..5 the shared address carries the CPU page index, zero-extended. The lookup RAM is enabled only in cycle 5, and its output is latched at the end of that cycle.
- R5: During cycles 6..7 the shared address is {latched page value, CPU offset without bit 0}. Main RAM is enabled in cycle 7 only when a CPU request is present.
- R6: A CPU write strobes exactly one bank in cycle 7. The write-data bus carries the CPU byte. Offset bit 0 selects the bank: 1 selects the high bank (bits 15:8) and 0 selects the low bank (bits 7:0).
- R7: A CPU read returns the byte lane chosen by offset bit 0, with the same encoding as R6. The byte comes with a one-cycle valid pulse in cycle 0 of the next period.
- R8: The lookup RAM enable and the main RAM enable are never high in the same cycle. Both enables are low in cycles 0 and 4, the cycles that follow each edge of E.
- R9: During reset, E, both enables, both write strobes and both valid outputs are low.
- R10: Without a CPU request, cycle 7 has no main RAM enable and no write strobe, even when the write input is high. In that case the RAM content is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, eight cycles per E period |
| rst_n | input | 1 | Active-low synchronous reset |
| e_clk | output | 1 | Generated E clock |
| vid_addr | input | VA_W | Video word address |
| vid_valid | output | 1 | Video byte valid |
| vid_data | output | DW | Video byte |
| cpu_req | input | 1 | CPU access request for this period |
| cpu_we | input | 1 | CPU access is a write |
| cpu_lk_addr | input | LKA_W | Index into the lookup RAM |
| cpu_off | input | OFS_W | Byte offset within the page; bit 0 selects the lane |
| cpu_wdata | input | DW | CPU write byte |
| cpu_rvalid | output | 1 | CPU read byte valid |
| cpu_rdata | output | DW | CPU read byte |
| mem_addr | output | AW | Shared address lines |
| lk_ce | output | 1 | Lookup RAM enable |
| lk_rdata | input | PAGE_W | Lookup RAM data |
| mr_ce | output | 1 | Main RAM enable |
| mr_we_hi | output | 1 | Write strobe, high bank |
| mr_we_lo | output | 1 | Write strobe, low bank |
| mr_wdata | output | DW | Write data to both banks |
| mr_rdata | input | 2*DW | Main RAM 16-bit read word |

## Verification
The bench uses the default parameters: a 16-bit page value, a 13-bit offset and a 19-bit video address. With these values the main-RAM address is 28 bits wide. Page values with high bits set therefore reach the top of the shared bus, which exposes any truncation or misplacement in the address mux. Page indices and offsets are kept in a narrow range, so that reads often hit recently written bytes. This makes lane mix-ups and stray strobes visible in the data read back, not only at the strobe pins.

// File: rtl/ssq_pkg.sv
package ssq_pkg;
  localparam int PH_W = 3;
  localparam logic [PH_W-1:0] PH_VID_STB = 3'd1;
  localparam logic [PH_W-1:0] PH_VID_END = 3'd3;
  localparam logic [PH_W-1:0] PH_LK_STB  = 3'd5;
  localparam logic [PH_W-1:0] PH_DAT_STB = 3'd7;

  typedef enum logic [1:0] {SEG_VID, SEG_LK, SEG_DAT} seg_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/ssq_phase.sv
module ssq_phase
  import ssq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  output logic [PH_W-1:0] ph,
  output logic            e_clk,
  output seg_e            seg,
  output logic            stb
);
  always_ff @(posedge clk) begin
    if (!rst_n) ph <= '0;
    else        ph <= ph + 1'b1;
  end

  assign e_clk = ph[PH_W-1];
  assign stb   = (ph == PH_VID_STB) || (ph == PH_LK_STB) || (ph == PH_DAT_STB);

  always_comb begin
    if (!ph[PH_W-1])       seg = SEG_VID;
    else if (ph < 3'd6)    seg = SEG_LK;
    else                   seg = SEG_DAT;
  end

  AST_E_RISE_FROM_VID: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(e_clk) |-> ($past(seg) == SEG_VID)); // R1
endmodule

// File: rtl/ssq_vid_marshal.sv
module ssq_vid_marshal #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic          rise,
  input  logic [2*DW-1:0] word,
  output logic          vld,
  output logic [DW-1:0] dat
);
  logic [DW-1:0] hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld  <= 1'b0;
      dat  <= '0;
      hold <= '0;
    end else begin
      vld <= 1'b0;
      if (cap) begin
        dat  <= word[DW-1:0];
        hold <= word[2*DW-1:DW];
        vld  <= 1'b1;
      end else if (rise) begin
        dat <= hold;
        vld <= 1'b1;
      end
    end
  end

  AST_CAP_GIVES_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> vld); // R3
  AST_BEATS_APART: assert property (@(posedge clk) disable iff (!rst_n)
    vld |=> !vld); // R3
endmodule

// File: rtl/ssq_cpu_path.sv
module ssq_cpu_path #(
  parameter int DW     = 8,
  parameter int PAGE_W = 16,
  parameter int OFS_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_cap,
  input  logic              dat_stb,
  input  logic              req,
  input  logic              we,
  input  logic [OFS_W-1:0]  off,
  input  logic [PAGE_W-1:0] lk_rdata,
  input  logic [2*DW-1:0]   mr_rdata,
  output logic [PAGE_W-1:0] page_q,
  output logic              acc_ce,
  output logic              we_hi,
  output logic              we_lo,
  output logic              rvld,
  output logic [DW-1:0]     rdat
);
  logic hi_lane;
  assign hi_lane = off[0];

  assign acc_ce = dat_stb && req;
  assign we_hi  = acc_ce && we &&  hi_lane;
  assign we_lo  = acc_ce && we && !hi_lane;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q <= '0;
      rvld   <= 1'b0;
      rdat   <= '0;
    end else begin
      rvld <= 1'b0;
      if (lk_cap) page_q <= lk_rdata;
      if (acc_ce && !we) begin
        rdat <= hi_lane ? mr_rdata[2*DW-1:DW] : mr_rdata[DW-1:0];
        rvld <= 1'b1;
      end
    end
  end

  AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_stb && req && !we) |=> rvld); // R7
  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !req |-> (!we_hi && !we_lo)); // R10
endmodule

// File: rtl/ssq_mem_sequencer.sv
module ssq_mem_sequencer
  import ssq_pkg::*;
#(
  parameter  int DW     = 8,
  parameter  int PAGE_W = 16,
  parameter  int OFS_W  = 13,
  parameter  int LKA_W  = 16,
  parameter  int VA_W   = 19,
  localparam int MA_W   = PAGE_W + OFS_W - 1,
  localparam int AW     = imax(imax(MA_W, LKA_W), VA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              e_clk,
  input  logic [VA_W-1:0]   vid_addr,
  output logic              vid_valid,
  output logic [DW-1:0]     vid_data,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [LKA_W-1:0]  cpu_lk_addr,
  input  logic [OFS_W-1:0]  cpu_off,
  input  logic [DW-1:0]     cpu_wdata,
  output logic              cpu_rvalid,
  output logic [DW-1:0]     cpu_rdata,
  output logic [AW-1:0]     mem_addr,
  output logic              lk_ce,
  input  logic [PAGE_W-1:0] lk_rdata,
  output logic              mr_ce,
  output logic              mr_we_hi,
  output logic              mr_we_lo,
  output logic [DW-1:0]     mr_wdata,
  input  logic [2*DW-1:0]   mr_rdata
);
  logic [PH_W-1:0]   ph;
  seg_e              seg;
  logic              stb;
  logic [PAGE_W-1:0] page_q;
  logic              cpu_ce;
  logic              vid_stb;

  ssq_phase u_phase (
    .clk(clk), .rst_n(rst_n), .ph(ph), .e_clk(e_clk), .seg(seg), .stb(stb)
  );

  assign vid_stb = stb && (seg == SEG_VID);
  assign lk_ce   = stb && (seg == SEG_LK);

  ssq_vid_marshal #(.DW(DW)) u_vid (
    .clk(clk), .rst_n(rst_n),
    .cap(vid_stb), .rise(ph == PH_VID_END),
    .word(mr_rdata), .vld(vid_valid), .dat(vid_data)
  );

  ssq_cpu_path #(.DW(DW), .PAGE_W(PAGE_W), .OFS_W(OFS_W)) u_cpu (
    .clk(clk), .rst_n(rst_n),
    .lk_cap(lk_ce), .dat_stb(stb && (seg == SEG_DAT)),
    .req(cpu_req), .we(cpu_we), .off(cpu_off),
    .lk_rdata(lk_rdata), .mr_rdata(mr_rdata),
    .page_q(page_q), .acc_ce(cpu_ce),
    .we_hi(mr_we_hi), .we_lo(mr_we_lo),
    .rvld(cpu_rvalid), .rdat(cpu_rdata)
  );

  assign mr_ce    = vid_stb || cpu_ce;
  assign mr_wdata = ((seg == SEG_DAT) && cpu_req && cpu_we) ? cpu_wdata : '0;

  always_comb begin
    mem_addr = '0;
    case (seg)
      SEG_VID: mem_addr[VA_W-1:0]  = vid_addr;
      SEG_LK:  mem_addr[LKA_W-1:0] = cpu_lk_addr;
      default: mem_addr[MA_W-1:0]  = {page_q, cpu_off[OFS_W-1:1]};
    endcase
  end

  AST_NO_DUAL_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_ce && mr_ce)); // R8
  AST_EDGE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (e_clk != $past(e_clk)) |-> (!lk_ce && !mr_ce)); // R8
  AST_WE_UNDER_CE: assert property (@(posedge clk) disable iff (!rst_n)
    (mr_we_hi || mr_we_lo) |-> (mr_ce && e_clk)); // R6
  AST_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mr_we_hi && mr_we_lo)); // R6
endmodule

// File: tb/ssq_mem_sequencer_bench.sv
module ssq_mem_sequencer_bench;
  localparam int DW = 8, PAGE_W = 16, OFS_W = 13, LKA_W = 16, VA_W = 19;
  localparam int AW = 28;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic              e_clk, vid_valid, cpu_rvalid, lk_ce, mr_ce, mr_we_hi, mr_we_lo;
  logic [VA_W-1:0]   vid_addr = '0;
  logic [DW-1:0]     vid_data, cpu_rdata, mr_wdata;
  logic              cpu_req = 1'b0, cpu_we = 1'b0;
  logic [LKA_W-1:0]  cpu_lk_addr = '0;
  logic [OFS_W-1:0]  cpu_off = '0;
  logic [DW-1:0]     cpu_wdata = '0;
  logic [AW-1:0]     mem_addr;
  logic [PAGE_W-1:0] lk_rdata = '0;
  logic [2*DW-1:0]   mr_rdata = '0;

  ssq_mem_sequencer u_ssq_mem_sequencer (
    .clk(clk), .rst_n(rst_n), .e_clk(e_clk),
    .vid_addr(vid_addr), .vid_valid(vid_valid), .vid_data(vid_data),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_lk_addr(cpu_lk_addr),
    .cpu_off(cpu_off), .cpu_wdata(cpu_wdata),
    .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
    .mem_addr(mem_addr), .lk_ce(lk_ce), .lk_rdata(lk_rdata),
    .mr_ce(mr_ce), .mr_we_hi(mr_we_hi), .mr_we_lo(mr_we_lo),
    .mr_wdata(mr_wdata), .mr_rdata(mr_rdata)
  );

  int total = 0, bad = 0;
  bit finished = 1'b0;
  logic [15:0] mem [int];

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] lkf(input int a);
    int v;
    v = (a & 16'hFFFF) * 40503 + 12345;
    return v[15:0];
  endfunction

  function automatic logic [15:0] rd(input int a);
    if (mem.exists(a)) return mem[a];
    return a[15:0] ^ 16'hC3A5 ^ {4'h0, a[27:16]};
  endfunction

  function automatic int main_addr(input logic [LKA_W-1:0] lk, input logic [OFS_W-1:0] off);
    return (int'(lkf(int'(lk))) << (OFS_W-1)) | int'(off >> 1);
  endfunction

  // script of CPU ops: {req, we, lk, off, wdata}
  typedef struct { bit rq; bit w; logic [LKA_W-1:0] lk; logic [OFS_W-1:0] off; logic [7:0] d; } op_t;
  op_t ops [$];

  initial begin
    int ph;
    int n_per;
    logic [15:0] vword;
    bit rd_pend;
    logic [7:0] rd_exp;
    int exp_addr;
    bit exp_ce, exp_hi, exp_lo;
    ops.push_back('{1, 1, 16'd5, 13'h0021, 8'hAA}); // R6 high lane write
    ops.push_back('{1, 0, 16'd5, 13'h0021, 8'h00}); // R7 read high
    ops.push_back('{1, 0, 16'd5, 13'h0020, 8'h00}); // R6 low lane untouched
    ops.push_back('{1, 1, 16'd5, 13'h0020, 8'h55}); // R6 low lane write
    ops.push_back('{1, 0, 16'd5, 13'h0020, 8'h00});
    ops.push_back('{1, 0, 16'd5, 13'h0021, 8'h00});
    ops.push_back('{0, 1, 16'd5, 13'h0021, 8'h77}); // R10 write without request
    ops.push_back('{1, 0, 16'd5, 13'h0021, 8'h00}); // R10 still AA
    ops.push_back('{1, 1, 16'hFFFF, 13'h1FFF, 8'h3C}); // R5 top bits
    ops.push_back('{1, 0, 16'hFFFF, 13'h1FFF, 8'h00});

    // R9 reset state
    repeat (3) @(negedge clk);
    check(!e_clk && !lk_ce && !mr_ce && !mr_we_hi && !mr_we_lo && !vid_valid && !cpu_rvalid,
          "R9 reset outputs", {e_clk, lk_ce, mr_ce, mr_we_hi, mr_we_lo, vid_valid, cpu_rvalid}, 0);
    rst_n = 1'b1;
    ph = 0; n_per = 0; rd_pend = 0; rd_exp = '0; vword = '0;
    while (n_per < 2100) begin
      @(negedge clk);
      ph = (ph + 1) % 8;
      // R1
      check(e_clk == (ph >= 4), "R1 e_clk", e_clk, ph >= 4);
      // address mux per segment
      if (ph < 4) exp_addr = int'(vid_addr);
      else if (ph < 6) exp_addr = int'(cpu_lk_addr);
      else exp_addr = main_addr(cpu_lk_addr, cpu_off);
      check(int'(mem_addr) == exp_addr, ph < 4 ? "R2 addr" : (ph < 6 ? "R4 addr" : "R5 addr"),
            mem_addr, exp_addr);
      // enables
      exp_ce = (ph == 1) || (ph == 7 && cpu_req);
      check(mr_ce == exp_ce, ph == 7 ? "R5 mr_ce" : "R2 mr_ce", mr_ce, exp_ce);
      check(lk_ce == (ph == 5), "R4 lk_ce", lk_ce, ph == 5);
      if (ph == 0 || ph == 4) check(!lk_ce && !mr_ce, "R8 edge idle", {lk_ce, mr_ce}, 0);
      check(!(lk_ce && mr_ce), "R8 dual ce", {lk_ce, mr_ce}, 0);
      exp_hi = (ph == 7) && cpu_req && cpu_we && cpu_off[0];
      exp_lo = (ph == 7) && cpu_req && cpu_we && !cpu_off[0];
      check(mr_we_hi == exp_hi && mr_we_lo == exp_lo,
            cpu_req ? "R6 strobes" : "R10 strobes", {mr_we_hi, mr_we_lo}, {exp_hi, exp_lo});
      if (exp_hi || exp_lo) check(mr_wdata == cpu_wdata, "R6 wdata", mr_wdata, cpu_wdata);
      // video stream
      if (ph == 2) check(vid_valid && vid_data == vword[7:0], "R3 low beat", {vid_valid, vid_data}, {1'b1, vword[7:0]});
      else if (ph == 4) check(vid_valid && vid_data == vword[15:8], "R3 high beat", {vid_valid, vid_data}, {1'b1, vword[15:8]});
      else check(!vid_valid, "R3 no beat", vid_valid, 0);
      // cpu read return
      if (ph == 0) begin
        check(cpu_rvalid == rd_pend, "R7 rvalid", cpu_rvalid, rd_pend);
        if (rd_pend) check(cpu_rdata == rd_exp, "R7 rdata", cpu_rdata, rd_exp);
        rd_pend = 0;
      end else check(!cpu_rvalid, "R7 stray rvalid", cpu_rvalid, 0);
      // model bookkeeping
      if (ph == 1) vword = rd(int'(vid_addr));
      if (ph == 7 && cpu_req && !cpu_we) begin
        logic [15:0] w;
        w = rd(main_addr(cpu_lk_addr, cpu_off));
        rd_exp = cpu_off[0] ? w[15:8] : w[7:0];
        rd_pend = 1;
      end
      // RAM reacts to the strobes it actually sees
      if (mr_we_hi || mr_we_lo) begin
        logic [15:0] w;
        w = rd(int'(mem_addr));
        if (mr_we_hi) w[15:8] = mr_wdata;
        if (mr_we_lo) w[7:0] = mr_wdata;
        mem[int'(mem_addr)] = w;
      end
      mr_rdata = rd(int'(mem_addr));
      lk_rdata = lkf(int'(mem_addr));
      // stimulus
      if (ph == 3) begin
        if (ops.size() > 0) begin
          op_t o;
          o = ops.pop_front();
          cpu_req = o.rq; cpu_we = o.w; cpu_lk_addr = o.lk; cpu_off = o.off; cpu_wdata = o.d;
        end else begin
          cpu_req = ($urandom % 4) != 0;
          cpu_we = $urandom % 2;
          cpu_lk_addr = LKA_W'($urandom % 4);
          cpu_off = OFS_W'($urandom % 16);
          cpu_wdata = 8'($urandom);
        end
      end
      if (ph == 7) begin
        vid_addr = VA_W'($urandom % 64);
        if (n_per % 50 == 7) vid_addr = {VA_W{1'b1}};
        n_per++;
      end
    end
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule